// File: doc/BRIEF.md
# DMA Command Sequence Assembler

This block watches the register writes that a host issues to start a page DMA on a flash controller. It builds a transfer descriptor from them: direction, page count, burst length, interrupt-on-complete, bank, page number and memory address. A DMA engine downstream takes the descriptor and runs the transfer, which is outside this block. The host sends the command as an ordered series of writes on one address class. Part of each command sits in the bus address and part sits in the data word.

A build-time parameter selects one of two command formats. The wide format uses three writes: a setup word, then the low 32 address bits, then the high 32 address bits. The narrow format uses four writes. Each of them carries a tag in its data word, and the address bits travel in the bus address. When the last write of a sequence is accepted, the block registers the descriptor and raises a one-cycle valid pulse.

Writes are taken only while the DMA-enable input is high. A write with the wrong tag, or a write whose bank differs from the bank of the first write, stops the sequence. The block then returns to waiting for a first write and sets a sticky protocol-error flag.

Top module: `dmaseq_asm`

## Requirements
- R1: After reset, desc_valid and proto_err are 0 and every descriptor output is 0.
- R2: A write is taken only when wr_valid is 1 and wr_addr[27:26] equals the class code (default 2'b10). A write to any other class has no effect on the sequence in progress.
- R3: While dma_en is 0, writes are ignored. A low dma_en also returns the assembler to the first step without setting proto_err, so a partial sequence is discarded.
- R4: In the wide format (FMT64=1), the first write is a setup word. Its tag, data[15:9] = 7'h10, must be correct. The write supplies direction = data[8], count = data[7:0], burst = data[23:16], interrupt = data[24], page = wr_addr[23:0] and bank = wr_addr[25:24].
- R5: In the wide format, the second write's data becomes desc_mem[31:0] and the third write's data becomes desc_mem[63:32]. The third write completes the descriptor.
- R6: In the narrow format (FMT64=0), the first write must carry data[31:9] = {16'h0, 7'h10}. It supplies direction = data[8], count = data[7:0], page = wr_addr[23:0] and bank = wr_addr[25:24].
- R7: In the narrow format, the second write must carry data 32'h2200, and its wr_addr[23:8] becomes desc_mem[31:16]. The third write must carry data 32'h2300, and its wr_addr[23:8] becomes desc_mem[15:0].
- R8: In the narrow format, the fourth write must carry data 32'h2400. Its wr_addr[16] becomes the interrupt flag and wr_addr[15:8] becomes the burst, and this write completes the descriptor.
- R9: desc_valid is high for exactly one cycle, in the cycle after the final write is sampled. The descriptor outputs change only in that cycle and hold their value until the next descriptor.
- R10: A write taken at a tagged step whose tag does not match stops the sequence. No descriptor is produced, proto_err is set, and the next taken write is treated as a first write.
- R11: A write at step two or later whose bank field differs from the bank of the first write stops the sequence in the same way and sets proto_err.
- R12: proto_err stays 1 until reset, including across later sequences that complete normally.
- R13: After a stopped sequence, a complete and correct sequence produces a correct descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | DMA enable; writes are ignored while low |
| wr_valid | input | 1 | Host write strobe |
| wr_addr | input | 2+BANK_W+24 | Host address: class, bank, payload |
| wr_data | input | 32 | Host write data |
| desc_valid | output | 1 | One-cycle descriptor-ready pulse |
| desc_bank | output | BANK_W | Target bank |
| desc_page | output | 24 | Page number |
| desc_write | output | 1 | 1 = write to flash, 0 = read |
| desc_count | output | 8 | Page count |
| desc_burst | output | 8 | Burst length in bytes |
| desc_irq | output | 1 | Interrupt on completion |
| desc_mem | output | 64 (FMT64=1) or 32 | Memory address |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The assertions check every cycle that the valid pulse is a single cycle and that descriptor outputs hold between pulses. They also check that every pulse follows an enabled write to the command class, that the error flag never falls, and that an error cycle never produces a descriptor. For each format, they also check the field that comes from the final write.

Only the bench scenarios can show the following: correct field placement from the earlier steps, the reset to the first step after a stopped sequence or a dropped enable, and that foreign-class writes mixed into a sequence leave it intact. These depend on the order of the writes, which the bench controls.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
   localparam int PAY_W   = 24;
   localparam int CLS_W   = 2;
   localparam int CNT_W   = 8;
   localparam int BURST_W = 8;

   localparam logic [6:0]  TAG_SETUP   = 7'h10;
   localparam logic [31:0] TAG_ADDR_HI = 32'h0000_2200;
   localparam logic [31:0] TAG_ADDR_LO = 32'h0000_2300;
   localparam logic [31:0] TAG_FINAL   = 32'h0000_2400;

   typedef logic [1:0] step_t;

   function automatic int steps_for(input bit fmt64);
      return fmt64 ? 3 : 4;
   endfunction

   function automatic int mem_w_for(input bit fmt64);
      return fmt64 ? 64 : 32;
   endfunction
endpackage

// File: rtl/dmaseq_filter.sv
module dmaseq_filter import dmaseq_pkg::*; #(
   parameter int          BANK_W     = 2,
   parameter logic [1:0]  CLASS_CODE = 2'b10,
   localparam int         ADDR_W     = CLS_W + BANK_W + PAY_W
) (
   input  logic              dma_en,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              take,
   output logic [BANK_W-1:0] bank,
   output logic [PAY_W-1:0]  pay
);
   logic [CLS_W-1:0] cls;

   always_comb begin
      cls  = wr_addr[ADDR_W-1 -: CLS_W];
      bank = wr_addr[PAY_W +: BANK_W];
      pay  = wr_addr[PAY_W-1:0];
      take = wr_valid && dma_en && (cls == CLASS_CODE);
   end
endmodule

// File: rtl/dmaseq_tagchk.sv
module dmaseq_tagchk import dmaseq_pkg::*; #(
   parameter bit FMT64 = 1'b1
) (
   input  step_t       step,
   input  logic [31:0] data,
   output logic        tag_ok
);
   generate
      if (FMT64) begin : g_wide
         always_comb begin
            tag_ok = (step != 2'd0) || (data[15:9] == TAG_SETUP);
         end
      end else begin : g_narrow
         always_comb begin
            unique case (step)
               2'd0:    tag_ok = (data[31:9] == {16'h0, TAG_SETUP});
               2'd1:    tag_ok = (data == TAG_ADDR_HI);
               2'd2:    tag_ok = (data == TAG_ADDR_LO);
               default: tag_ok = (data == TAG_FINAL);
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/dmaseq_seq.sv
module dmaseq_seq import dmaseq_pkg::*; #(
   parameter int NSTEPS = 3,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_en,
   input  logic              take,
   input  logic              tag_ok,
   input  logic [BANK_W-1:0] bank,
   output step_t             step,
   output logic              advance,
   output logic              last,
   output logic              proto_err
);
   localparam step_t LAST_STEP = step_t'(NSTEPS - 1);

   logic [BANK_W-1:0] bank_q;
   logic              bank_bad;
   logic              abort;

   always_comb begin
      bank_bad = (step != 2'd0) && (bank != bank_q);
      abort    = take && (!tag_ok || bank_bad);
      advance  = take && !abort;
      last     = advance && (step == LAST_STEP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step      <= 2'd0;
         bank_q    <= '0;
         proto_err <= 1'b0;
      end else if (!dma_en) begin
         step <= 2'd0;
      end else if (abort) begin
         step      <= 2'd0;
         proto_err <= 1'b1;
      end else if (last) begin
         step <= 2'd0;
      end else if (advance) begin
         step <= step + 2'd1;
         if (step == 2'd0) bank_q <= bank;
      end
   end
endmodule

// File: rtl/dmaseq_collect.sv
module dmaseq_collect import dmaseq_pkg::*; #(
   parameter bit FMT64  = 1'b1,
   parameter int BANK_W = 2,
   localparam int MEM_W = mem_w_for(FMT64)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               advance,
   input  logic               last,
   input  step_t              step,
   input  logic [BANK_W-1:0]  bank,
   input  logic [PAY_W-1:0]   pay,
   input  logic [31:0]        data,
   output logic               desc_valid,
   output logic [BANK_W-1:0]  desc_bank,
   output logic [PAY_W-1:0]   desc_page,
   output logic               desc_write,
   output logic [CNT_W-1:0]   desc_count,
   output logic [BURST_W-1:0] desc_burst,
   output logic               desc_irq,
   output logic [MEM_W-1:0]   desc_mem
);
   logic [BANK_W-1:0] st_bank;
   logic [PAY_W-1:0]  st_page;
   logic              st_write;
   logic [CNT_W-1:0]  st_count;
   logic              first;

   assign first = advance && (step == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_bank  <= '0;
         st_page  <= '0;
         st_write <= 1'b0;
         st_count <= '0;
      end else if (first) begin
         st_bank  <= bank;
         st_page  <= pay;
         st_write <= data[8];
         st_count <= data[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_valid <= 1'b0;
         desc_bank  <= '0;
         desc_page  <= '0;
         desc_write <= 1'b0;
         desc_count <= '0;
      end else begin
         desc_valid <= last;
         if (last) begin
            desc_bank  <= st_bank;
            desc_page  <= st_page;
            desc_write <= st_write;
            desc_count <= st_count;
         end
      end
   end

   generate
      if (FMT64) begin : g_wide
         logic [BURST_W-1:0] st_burst;
         logic               st_irq;
         logic [31:0]        st_lo;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_burst <= '0;
               st_irq   <= 1'b0;
               st_lo    <= '0;
            end else if (first) begin
               st_burst <= data[16 +: BURST_W];
               st_irq   <= data[24];
            end else if (advance && step == 2'd1) begin
               st_lo <= data;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               desc_burst <= '0;
               desc_irq   <= 1'b0;
               desc_mem   <= '0;
            end else if (last) begin
               desc_burst <= st_burst;
               desc_irq   <= st_irq;
               desc_mem   <= {data, st_lo};
            end
         end
      end else begin : g_narrow
         logic [15:0] st_hi;
         logic [15:0] st_lo;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_hi <= '0;
               st_lo <= '0;
            end else if (advance && step == 2'd1) begin
               st_hi <= pay[23:8];
            end else if (advance && step == 2'd2) begin
               st_lo <= pay[23:8];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               desc_burst <= '0;
               desc_irq   <= 1'b0;
               desc_mem   <= '0;
            end else if (last) begin
               desc_burst <= pay[8 +: BURST_W];
               desc_irq   <= pay[16];
               desc_mem   <= {st_hi, st_lo};
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dmaseq_asm.sv
module dmaseq_asm import dmaseq_pkg::*; #(
   parameter bit         FMT64      = 1'b1,
   parameter int         BANK_W     = 2,
   parameter logic [1:0] CLASS_CODE = 2'b10,
   localparam int        ADDR_W     = CLS_W + BANK_W + PAY_W,
   localparam int        MEM_W      = mem_w_for(FMT64)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dma_en,
   input  logic               wr_valid,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [31:0]        wr_data,
   output logic               desc_valid,
   output logic [BANK_W-1:0]  desc_bank,
   output logic [PAY_W-1:0]   desc_page,
   output logic               desc_write,
   output logic [CNT_W-1:0]   desc_count,
   output logic [BURST_W-1:0] desc_burst,
   output logic               desc_irq,
   output logic [MEM_W-1:0]   desc_mem,
   output logic               proto_err
);
   localparam int NSTEPS = steps_for(FMT64);

   generate
      if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
         $error("dmaseq_asm: BANK_W must lie in 1..4");
      end
      if (NSTEPS > 4) begin : g_bad_steps
         $error("dmaseq_asm: step counter holds at most four steps");
      end
   endgenerate

   logic              take;
   logic [BANK_W-1:0] bank;
   logic [PAY_W-1:0]  pay;
   logic              tag_ok;
   step_t             step;
   logic              advance;
   logic              last;

   dmaseq_filter #(.BANK_W(BANK_W), .CLASS_CODE(CLASS_CODE)) i_filter (
      .dma_en   (dma_en),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .take     (take),
      .bank     (bank),
      .pay      (pay)
   );

   dmaseq_tagchk #(.FMT64(FMT64)) i_tagchk (
      .step   (step),
      .data   (wr_data),
      .tag_ok (tag_ok)
   );

   dmaseq_seq #(.NSTEPS(NSTEPS), .BANK_W(BANK_W)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .dma_en    (dma_en),
      .take      (take),
      .tag_ok    (tag_ok),
      .bank      (bank),
      .step      (step),
      .advance   (advance),
      .last      (last),
      .proto_err (proto_err)
   );

   dmaseq_collect #(.FMT64(FMT64), .BANK_W(BANK_W)) i_collect (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance    (advance),
      .last       (last),
      .step       (step),
      .bank       (bank),
      .pay        (pay),
      .data       (wr_data),
      .desc_valid (desc_valid),
      .desc_bank  (desc_bank),
      .desc_page  (desc_page),
      .desc_write (desc_write),
      .desc_count (desc_count),
      .desc_burst (desc_burst),
      .desc_irq   (desc_irq),
      .desc_mem   (desc_mem)
   );
endmodule

// File: rtl/dmaseq_asm_chk.sv
module dmaseq_asm_chk import dmaseq_pkg::*; #(
   parameter bit         FMT64      = 1'b1,
   parameter int         BANK_W     = 2,
   parameter logic [1:0] CLASS_CODE = 2'b10,
   localparam int        ADDR_W     = CLS_W + BANK_W + PAY_W,
   localparam int        MEM_W      = mem_w_for(FMT64)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dma_en,
   input logic               wr_valid,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [31:0]        wr_data,
   input logic               desc_valid,
   input logic [BANK_W-1:0]  desc_bank,
   input logic [PAY_W-1:0]   desc_page,
   input logic [BURST_W-1:0] desc_burst,
   input logic               desc_irq,
   input logic [MEM_W-1:0]   desc_mem,
   input logic               proto_err
);
   p_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> $past(wr_valid && (wr_addr[ADDR_W-1 -: CLS_W] == CLASS_CODE)));

   p_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> $past(dma_en));

   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |=> !desc_valid);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !desc_valid |-> ($stable(desc_mem) && $stable(desc_page) && $stable(desc_bank)));

   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(proto_err) |-> !desc_valid);

   p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   generate
      if (FMT64) begin : g_wide
         p_hi_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
            desc_valid |-> (desc_mem[MEM_W-1 -: 32] == $past(wr_data)));
      end else begin : g_narrow
         p_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
            desc_valid |-> ((desc_irq == $past(wr_addr[16]))
                            && (desc_burst == $past(wr_addr[15:8]))));
      end
   endgenerate
endmodule

bind dmaseq_asm dmaseq_asm_chk #(.FMT64(FMT64), .BANK_W(BANK_W), .CLASS_CODE(CLASS_CODE)) i_dmaseq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dma_en     (dma_en),
   .wr_valid   (wr_valid),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .desc_valid (desc_valid),
   .desc_bank  (desc_bank),
   .desc_page  (desc_page),
   .desc_burst (desc_burst),
   .desc_irq   (desc_irq),
   .desc_mem   (desc_mem),
   .proto_err  (proto_err)
);

// File: tb/test_dmaseq_asm.sv
module test_dmaseq_asm;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dma_en = 1'b1;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // wide-format instance
   logic        a_valid = 1'b0;
   logic [27:0] a_addr = '0;
   logic [31:0] a_data = '0;
   logic        a_dv, a_wr, a_irq, a_err;
   logic [1:0]  a_bank;
   logic [23:0] a_page;
   logic [7:0]  a_cnt, a_burst;
   logic [63:0] a_mem;

   // narrow-format instance
   logic        b_valid = 1'b0;
   logic [27:0] b_addr = '0;
   logic [31:0] b_data = '0;
   logic        b_dv, b_wr, b_irq, b_err;
   logic [1:0]  b_bank;
   logic [23:0] b_page;
   logic [7:0]  b_cnt, b_burst;
   logic [31:0] b_mem;

   dmaseq_asm #(.FMT64(1'b1)) i_dmaseq_asm (
      .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
      .wr_valid(a_valid), .wr_addr(a_addr), .wr_data(a_data),
      .desc_valid(a_dv), .desc_bank(a_bank), .desc_page(a_page),
      .desc_write(a_wr), .desc_count(a_cnt), .desc_burst(a_burst),
      .desc_irq(a_irq), .desc_mem(a_mem), .proto_err(a_err)
   );

   dmaseq_asm #(.FMT64(1'b0)) i_dmaseq_asm_f32 (
      .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
      .wr_valid(b_valid), .wr_addr(b_addr), .wr_data(b_data),
      .desc_valid(b_dv), .desc_bank(b_bank), .desc_page(b_page),
      .desc_write(b_wr), .desc_count(b_cnt), .desc_burst(b_burst),
      .desc_irq(b_irq), .desc_mem(b_mem), .proto_err(b_err)
   );

   function automatic logic [27:0] mk(input logic [1:0] c, input logic [1:0] b,
                                      input logic [23:0] p);
      return {c, b, p};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input bit narrow, input logic [27:0] addr, input logic [31:0] data);
      @(negedge clk);
      if (narrow) begin b_valid = 1'b1; b_addr = addr; b_data = data; end
      else        begin a_valid = 1'b1; a_addr = addr; a_data = data; end
      @(negedge clk);
      a_valid = 1'b0;
      b_valid = 1'b0;
   endtask

   task automatic noise(input bit narrow);
      wr(narrow, mk(2'b11, 2'b01, 24'hFFFFFF), 32'hFFFF_FFFF);
      wr(narrow, mk(2'b01, 2'b10, 24'h000000), 32'h0000_2400);
   endtask

   // wide format: three writes; R4 R5 R9
   task automatic seq64(input logic [1:0] bank, input logic [23:0] page, input bit w,
                        input logic [7:0] cnt, input logic [7:0] burst, input bit irq,
                        input logic [63:0] mem, input bit mix, input string req);
      logic [43:0] exp_f;
      exp_f = {bank, page, w, cnt, burst, irq};
      wr(1'b0, mk(2'b10, bank, page), {7'h00, irq, burst, 7'h10, w, cnt});
      chk({req, " no early valid"}, {63'h0, a_dv}, 64'h0);
      if (mix) noise(1'b0);
      wr(1'b0, mk(2'b10, bank, page), mem[31:0]);
      chk({req, " no early valid"}, {63'h0, a_dv}, 64'h0);
      if (mix) noise(1'b0);
      wr(1'b0, mk(2'b10, bank, page), mem[63:32]);
      chk({req, " valid after last write"}, {63'h0, a_dv}, 64'h1);
      chk({req, " R4 fields"}, {20'h0, a_bank, a_page, a_wr, a_cnt, a_burst, a_irq}, {20'h0, exp_f});
      chk({req, " R5 address"}, a_mem, mem);
      @(negedge clk);
      chk({req, " R9 pulse ends"}, {63'h0, a_dv}, 64'h0);
      chk({req, " R9 hold"}, a_mem, mem);
   endtask

   // narrow format: four writes; R6 R7 R8 R9
   task automatic seq32(input logic [1:0] bank, input logic [23:0] page, input bit w,
                        input logic [7:0] cnt, input logic [7:0] burst, input bit irq,
                        input logic [31:0] mem, input bit mix, input string req);
      logic [43:0] exp_f;
      exp_f = {bank, page, w, cnt, burst, irq};
      wr(1'b1, mk(2'b10, bank, page), {16'h0, 7'h10, w, cnt});
      chk({req, " no early valid"}, {63'h0, b_dv}, 64'h0);
      if (mix) noise(1'b1);
      wr(1'b1, mk(2'b10, bank, {mem[31:16], 8'h5A}), 32'h2200);
      chk({req, " no early valid"}, {63'h0, b_dv}, 64'h0);
      if (mix) noise(1'b1);
      wr(1'b1, mk(2'b10, bank, {mem[15:0], 8'hA5}), 32'h2300);
      chk({req, " no early valid"}, {63'h0, b_dv}, 64'h0);
      wr(1'b1, mk(2'b10, bank, {7'h0, irq, burst, 8'h00}), 32'h2400);
      chk({req, " valid after last write"}, {63'h0, b_dv}, 64'h1);
      chk({req, " R6 R8 fields"}, {20'h0, b_bank, b_page, b_wr, b_cnt, b_burst, b_irq}, {20'h0, exp_f});
      chk({req, " R7 address"}, {32'h0, b_mem}, {32'h0, mem});
      @(negedge clk);
      chk({req, " R9 pulse ends"}, {63'h0, b_dv}, 64'h0);
      chk({req, " R9 hold"}, {32'h0, b_mem}, {32'h0, mem});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 wide outputs", {a_dv, a_err, a_bank, a_page, a_wr, a_cnt, a_burst, a_irq} , 64'h0);
      chk("R1 wide address", a_mem, 64'h0);
      chk("R1 narrow outputs", {b_dv, b_err, b_bank, b_page, b_wr, b_cnt, b_burst, b_irq}, 64'h0);
      chk("R1 narrow address", {32'h0, b_mem}, 64'h0);
      rst_n = 1'b1;

      // R4 R5 sweep, wide format
      for (int bk = 0; bk < 4; bk++)
         for (int w = 0; w < 2; w++)
            for (int k = 0; k < 4; k++) begin
               int i;
               i = bk * 8 + w * 4 + k;
               seq64(2'(bk), 24'h0ABCDE ^ 24'(i * 24'h01F3), w[0], 8'(i * 29 + 1),
                     8'(8'h40 + i), (i % 3) != 0,
                     {32'hC0DE0000 + 32'(i * 32'h1111), 32'h12340000 ^ 32'(i * 32'h10101)},
                     0, "R4 R5 sweep");
            end

      // R6 R7 R8 sweep, narrow format
      for (int bk = 0; bk < 4; bk++)
         for (int w = 0; w < 2; w++)
            for (int k = 0; k < 3; k++) begin
               int i;
               i = bk * 6 + w * 3 + k;
               seq32(2'(bk), 24'h13579B + 24'(i * 24'h0201), w[0], 8'(255 - i * 7),
                     8'(8'h40 ^ i), (i % 2) == 0,
                     32'hDEAD0000 ^ 32'(i * 32'h00050703), 0, "R6 R7 R8 sweep");
            end

      // R2 foreign-class writes interleaved
      seq64(2'd1, 24'h00F00D, 1'b1, 8'd3, 8'h40, 1'b1, 64'h0123_4567_89AB_CDEF, 1, "R2 wide");
      seq32(2'd2, 24'h00BEEF, 1'b0, 8'd9, 8'h40, 1'b1, 32'hFACE_B00C, 1, "R2 narrow");
      chk("R2 no error from foreign writes", {62'h0, a_err, b_err}, 64'h0);

      // R3 disabled writes ignored
      dma_en = 1'b0;
      wr(1'b0, mk(2'b10, 2'd0, 24'h1), {7'h0, 1'b1, 8'h40, 7'h10, 1'b0, 8'd1});
      chk("R3 disabled no valid", {63'h0, a_dv}, 64'h0);
      wr(1'b0, mk(2'b10, 2'd0, 24'h1), 32'h1111_1111);
      wr(1'b0, mk(2'b10, 2'd0, 24'h1), 32'h2222_2222);
      chk("R3 disabled no valid", {63'h0, a_dv}, 64'h0);
      dma_en = 1'b1;
      seq64(2'd3, 24'h222222, 1'b0, 8'd5, 8'h40, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 0, "R3 after disable");
      // R3 enable drop mid-sequence discards partial
      wr(1'b0, mk(2'b10, 2'd0, 24'h7), {7'h0, 1'b1, 8'h40, 7'h10, 1'b1, 8'd2});
      wr(1'b0, mk(2'b10, 2'd0, 24'h7), 32'h5555_5555);
      @(negedge clk); dma_en = 1'b0;
      @(negedge clk); dma_en = 1'b1;
      seq64(2'd2, 24'h333333, 1'b1, 8'd6, 8'h40, 1'b0, 64'h0F0F_0F0F_F0F0_F0F0, 0, "R3 drop mid-sequence");
      chk("R3 drop sets no error", {63'h0, a_err}, 64'h0);

      // R11 bank mismatch, wide
      wr(1'b0, mk(2'b10, 2'd0, 24'h9), {7'h0, 1'b1, 8'h40, 7'h10, 1'b0, 8'd1});
      wr(1'b0, mk(2'b10, 2'd1, 24'h9), 32'h9999_9999);
      chk("R11 bank mismatch sets error", {63'h0, a_err}, 64'h1);
      chk("R11 no valid", {63'h0, a_dv}, 64'h0);
      seq64(2'd2, 24'h444444, 1'b0, 8'd7, 8'h40, 1'b1, 64'h1357_9BDF_2468_ACE0, 0, "R13 after bank abort");
      chk("R12 error sticky", {63'h0, a_err}, 64'h1);

      // R10 bad setup tag, wide
      wr(1'b0, mk(2'b10, 2'd0, 24'h9), {7'h0, 1'b1, 8'h40, 7'h11, 1'b0, 8'd1});
      chk("R10 bad tag no valid", {63'h0, a_dv}, 64'h0);
      seq64(2'd1, 24'h555555, 1'b1, 8'd8, 8'h40, 1'b1, 64'h8888_7777_6666_5555, 0, "R13 after tag abort");

      // R10 bad tag at step three, narrow
      wr(1'b1, mk(2'b10, 2'd1, 24'h3), {16'h0, 7'h10, 1'b0, 8'd4});
      wr(1'b1, mk(2'b10, 2'd1, 24'h1200), 32'h2200);
      wr(1'b1, mk(2'b10, 2'd1, 24'h3400), 32'h2200);
      chk("R10 narrow tag error", {63'h0, b_err}, 64'h1);
      chk("R10 narrow no valid", {63'h0, b_dv}, 64'h0);
      seq32(2'd0, 24'h666666, 1'b1, 8'd2, 8'h40, 1'b1, 32'h0BAD_F00D, 0, "R13 narrow after tag abort");

      // R11 narrow bank mismatch, then recovery
      wr(1'b1, mk(2'b10, 2'd3, 24'h3), {16'h0, 7'h10, 1'b1, 8'd4});
      wr(1'b1, mk(2'b10, 2'd0, 24'h1200), 32'h2200);
      seq32(2'd3, 24'h777777, 1'b0, 8'd1, 8'h40, 1'b0, 32'h1234_5678, 0, "R11 R13 narrow bank abort");
      chk("R12 narrow error sticky", {63'h0, b_err}, 64'h1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule